// File: doc/BRIEF.md
# DDR Low-Power Mode and Refresh Tracker

This block follows the clock-enable line of a double-data-rate SDRAM and keeps track of which low-power mode the device is in: normal operation, precharge power-down, active power-down (only when a parameter allows it) or self-refresh. It watches the command pins and an all-banks-idle flag on every rising clock edge. On a change of the clock-enable level it decides whether the mode change is legal, and it raises a one-cycle error flag when it is not.

Beside the mode tracking, the block schedules periodic refresh. An interval counter raises a one-cycle refresh request every `REFI` clocks while the device is outside self-refresh. A refresh address made of a bank field and a row field steps forward on every auto-refresh command. While the device is in self-refresh, the same address steps forward once per interval. In that mode a three-bit partial-array code limits the stepping to the selected low-numbered banks. After a self-refresh exit, a guard window flags any command that would open a row or change device state too early. A second guard flags clock-enable pulses that are too short.

Top module: `lpm_ctrl`

## Requirements
- R1: While reset is asserted and after its release, `pwr_state` is 2'b00 (normal), `ref_req` is 0, `ref_addr` is 0 and all four error flags are 0.
- R2: A clock edge that samples CKE low after a high CKE, together with a refresh command (cs_n=0, ras_n=0, cas_n=0, we_n=1) and `all_idle`=1, moves `pwr_state` to 2'b11 (self-refresh) after that edge.
- R3: A falling CKE with a no-operation command (cs_n=0, ras_n=1, cas_n=1, we_n=1) or a deselect (cs_n=1), together with `all_idle`=1, moves `pwr_state` to 2'b01 (precharge power-down).
- R4: A falling CKE while `all_idle`=0, or with any command other than no-operation, deselect or refresh, leaves `pwr_state` at 2'b00. It also raises `entry_err` for exactly one cycle. With `ALLOW_ACT_PD`=1, a no-operation entry while banks are open goes to 2'b10 instead.
- R5: While CKE is sampled low on two consecutive edges, the mode is held and every command is ignored. The refresh address does not move on refresh commands, and no error flag is raised.
- R6: A rising CKE in any low-power mode returns `pwr_state` to 2'b00. If the command on that edge is neither no-operation nor deselect, `exit_err` is raised for one cycle.
- R7: For the `EXIT_CYC` edges that follow a self-refresh exit, any command other than no-operation, deselect or a column command (cs_n=0, ras_n=1, cas_n=0) raises `early_err` for one cycle. From edge `EXIT_CYC`+1 onward, such commands are accepted without a flag.
- R8: If CKE changes level after holding its previous level for fewer than `CKE_MIN` sampled edges, `pulse_err` is raised for one cycle.
- R9: Outside self-refresh, `ref_req` pulses high for one cycle every `REFI` clocks, the first time `REFI` edges after reset. Entering or leaving self-refresh restarts the interval, and no request appears during self-refresh.
- R10: An auto-refresh command with CKE high on both edges, in normal mode, with `all_idle`=1, increments `ref_addr` ({bank, row}) by one. The same command with `all_idle`=0 leaves it unchanged.
- R11: In self-refresh, `ref_addr` advances once per interval and wraps to 0 when the next address falls outside the selected banks. Code 3'b000 selects all banks, 3'b001 the lower half and 3'b010 the lowest quarter; any other code selects all banks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cke | input | 1 | Clock-enable level sampled each edge |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| all_idle | input | 1 | All banks precharged |
| pasr_sel | input | 3 | Partial-array refresh code |
| pwr_state | output | 2 | 00 normal, 01 precharge power-down, 10 active power-down, 11 self-refresh |
| ref_req | output | 1 | One-cycle refresh request |
| ref_addr | output | BANK_W+ROW_W | Refresh address {bank, row} |
| entry_err | output | 1 | Illegal low-power entry |
| exit_err | output | 1 | Illegal command on a wake-up edge |
| early_err | output | 1 | Command inside the self-refresh exit window |
| pulse_err | output | 1 | CKE level held too briefly |

## Verification
The bench places commands on the last edge inside the exit window and on the first edge after it. A guard window that is off by one would flag a legal activate or let an early one pass. It drives self-refresh long enough for the address to run past the selected banks under both partial codes. A design that masked the wrong bank bit, or that wrapped only at the full array size, would show a nonzero address where zero is expected. It also sends refresh and activate commands while CKE is low, which exposes a design that acts on commands during a held mode. A single-edge CKE dip must raise the pulse error, and a two-edge one must not.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

   typedef enum logic [1:0] {
      PS_ON   = 2'b00,
      PS_PDN  = 2'b01,
      PS_APD  = 2'b10,
      PS_SREF = 2'b11
   } pstate_e;

   typedef enum logic [1:0] {
      CC_IDLE  = 2'b00,
      CC_REF   = 2'b01,
      CC_COL   = 2'b10,
      CC_OTHER = 2'b11
   } cmd_cls_e;

endpackage

// File: rtl/lpm_cmd_class.sv
module lpm_cmd_class
   import lpm_pkg::*;
(
   input  logic     cs_n,
   input  logic     ras_n,
   input  logic     cas_n,
   input  logic     we_n,
   output cmd_cls_e cls
);

   always_comb begin
      if (cs_n) begin
         cls = CC_IDLE;
      end else if (ras_n && cas_n && we_n) begin
         cls = CC_IDLE;
      end else if (!ras_n && !cas_n && we_n) begin
         cls = CC_REF;
      end else if (ras_n && !cas_n) begin
         cls = CC_COL;
      end else begin
         cls = CC_OTHER;
      end
   end

endmodule

// File: rtl/lpm_refresh_track.sv
module lpm_refresh_track
   import lpm_pkg::*;
#(
   parameter int ROW_W  = 13,
   parameter int BANK_W = 2,
   parameter int REFI   = 1040
)(
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_sref,
   input  logic                    restart,
   input  logic                    auto_ref,
   input  logic [2:0]              pasr_sel,
   output logic                    ref_req,
   output logic [BANK_W+ROW_W-1:0] ref_addr
);

   localparam int ADDR_W = BANK_W + ROW_W;
   localparam int NBANK  = 1 << BANK_W;
   localparam int CNT_W  = $clog2(REFI);

   if (REFI < 2) begin : g_bad_refi
      $error("lpm_refresh_track: REFI must be 2 or more");
   end
   if (BANK_W < 2) begin : g_bad_bank
      $error("lpm_refresh_track: BANK_W must be 2 or more for quarter-array refresh");
   end

   logic [CNT_W-1:0]  cnt_q;
   logic              expire;
   logic              adv_sref;
   logic [BANK_W:0]   lim;
   logic [ADDR_W-1:0] addr_inc;
   logic [BANK_W-1:0] inc_bank;

   assign expire   = (cnt_q == CNT_W'(REFI - 1)) && !restart;
   assign adv_sref = expire && in_sref;
   assign addr_inc = ref_addr + ADDR_W'(1);
   assign inc_bank = addr_inc[ADDR_W-1:ROW_W];

   always_comb begin
      case (pasr_sel)
         3'b001:  lim = (BANK_W+1)'(NBANK >> 1);
         3'b010:  lim = (BANK_W+1)'(NBANK >> 2);
         default: lim = (BANK_W+1)'(NBANK);
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (restart || expire) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + CNT_W'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ref_req <= 1'b0;
      end else begin
         ref_req <= expire && !in_sref;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ref_addr <= '0;
      end else if (adv_sref) begin
         ref_addr <= ({1'b0, inc_bank} >= lim) ? '0 : addr_inc;
      end else if (auto_ref) begin
         ref_addr <= addr_inc;
      end
   end

   AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n) ref_req |=> !ref_req); // R9
   AST_SREF_BANK_RANGE: assert property (@(posedge clk) disable iff (!rst_n) adv_sref |=> ({1'b0, ref_addr[ADDR_W-1:ROW_W]} < $past(lim))); // R11

endmodule

// File: rtl/lpm_exit_guard.sv
module lpm_exit_guard
   import lpm_pkg::*;
#(
   parameter int EXIT_CYC = 20,
   parameter int CKE_MIN  = 2
)(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     cke,
   input  logic     cke_q,
   input  logic     sref_exit,
   input  cmd_cls_e cls,
   output logic     early_err,
   output logic     pulse_err
);

   localparam int WIN_W = $clog2(EXIT_CYC + 1);
   localparam int HLD_W = $clog2(CKE_MIN + 1);

   if (EXIT_CYC < 1) begin : g_bad_exit
      $error("lpm_exit_guard: EXIT_CYC must be 1 or more");
   end
   if (CKE_MIN < 1) begin : g_bad_cke
      $error("lpm_exit_guard: CKE_MIN must be 1 or more");
   end

   logic [WIN_W-1:0] win_q;
   logic [HLD_W-1:0] hold_q;
   logic             win_open;
   logic             bad_cmd;
   logic             cke_edge;

   assign win_open = (win_q != '0);
   assign bad_cmd  = (cls == CC_REF) || (cls == CC_OTHER);
   assign cke_edge = (cke != cke_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_q <= '0;
      end else if (sref_exit) begin
         win_q <= WIN_W'(EXIT_CYC);
      end else if (win_open) begin
         win_q <= win_q - WIN_W'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= HLD_W'(CKE_MIN);
      end else if (cke_edge) begin
         hold_q <= HLD_W'(1);
      end else if (hold_q < HLD_W'(CKE_MIN)) begin
         hold_q <= hold_q + HLD_W'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         early_err <= 1'b0;
         pulse_err <= 1'b0;
      end else begin
         early_err <= win_open && cke && cke_q && bad_cmd;
         pulse_err <= cke_edge && (hold_q < HLD_W'(CKE_MIN));
      end
   end

   AST_EARLY_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n) early_err |-> $past(win_open)); // R7
   AST_WINDOW_LOADED: assert property (@(posedge clk) disable iff (!rst_n) sref_exit |=> (win_q == WIN_W'(EXIT_CYC))); // R7

endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
   import lpm_pkg::*;
#(
   parameter int ROW_W        = 13,
   parameter int BANK_W       = 2,
   parameter int REFI         = 1040,
   parameter int EXIT_CYC     = 20,
   parameter int CKE_MIN      = 2,
   parameter bit ALLOW_ACT_PD = 1'b0
)(
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cke,
   input  logic                    cs_n,
   input  logic                    ras_n,
   input  logic                    cas_n,
   input  logic                    we_n,
   input  logic                    all_idle,
   input  logic [2:0]              pasr_sel,
   output logic [1:0]              pwr_state,
   output logic                    ref_req,
   output logic [BANK_W+ROW_W-1:0] ref_addr,
   output logic                    entry_err,
   output logic                    exit_err,
   output logic                    early_err,
   output logic                    pulse_err
);

   cmd_cls_e cls;
   pstate_e  state_q, state_d;
   pstate_e  busy_tgt;
   logic     busy_ok;
   logic     cke_q;
   logic     fall, rise, steady;
   logic     ent_bad, ext_bad;
   logic     sref_exit, restart, auto_ref;

   lpm_cmd_class u_cls (
      .cs_n  (cs_n),
      .ras_n (ras_n),
      .cas_n (cas_n),
      .we_n  (we_n),
      .cls   (cls)
   );

   if (ALLOW_ACT_PD) begin : g_act_pd
      assign busy_tgt = PS_APD;
      assign busy_ok  = 1'b1;
   end else begin : g_no_act_pd
      assign busy_tgt = PS_ON;
      assign busy_ok  = 1'b0;
   end

   assign fall   = cke_q && !cke;
   assign rise   = !cke_q && cke;
   assign steady = cke_q && cke;

   always_comb begin
      state_d = state_q;
      ent_bad = 1'b0;
      ext_bad = 1'b0;
      if (state_q == PS_ON) begin
         if (fall) begin
            if (cls == CC_IDLE) begin
               if (all_idle) begin
                  state_d = PS_PDN;
               end else if (busy_ok) begin
                  state_d = busy_tgt;
               end else begin
                  ent_bad = 1'b1;
               end
            end else if (cls == CC_REF && all_idle) begin
               state_d = PS_SREF;
            end else begin
               ent_bad = 1'b1;
            end
         end
      end else if (rise) begin
         state_d = PS_ON;
         ext_bad = (cls != CC_IDLE);
      end
   end

   assign sref_exit = (state_q == PS_SREF) && rise;
   assign restart   = (state_d == PS_SREF) != (state_q == PS_SREF);
   assign auto_ref  = (state_q == PS_ON) && steady && (cls == CC_REF) && all_idle;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= PS_ON;
         cke_q     <= 1'b1;
         entry_err <= 1'b0;
         exit_err  <= 1'b0;
      end else begin
         state_q   <= state_d;
         cke_q     <= cke;
         entry_err <= ent_bad;
         exit_err  <= ext_bad;
      end
   end

   assign pwr_state = state_q;

   lpm_refresh_track #(
      .ROW_W  (ROW_W),
      .BANK_W (BANK_W),
      .REFI   (REFI)
   ) u_ref (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_sref  (state_q == PS_SREF),
      .restart  (restart),
      .auto_ref (auto_ref),
      .pasr_sel (pasr_sel),
      .ref_req  (ref_req),
      .ref_addr (ref_addr)
   );

   lpm_exit_guard #(
      .EXIT_CYC (EXIT_CYC),
      .CKE_MIN  (CKE_MIN)
   ) u_guard (
      .clk       (clk),
      .rst_n     (rst_n),
      .cke       (cke),
      .cke_q     (cke_q),
      .sref_exit (sref_exit),
      .cls       (cls),
      .early_err (early_err),
      .pulse_err (pulse_err)
   );

   AST_SREF_NEEDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n) $rose(state_q == PS_SREF) |-> $past(all_idle)); // R2
   AST_PDN_NEEDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n) $rose(state_q == PS_PDN) |-> $past(all_idle)); // R3
   AST_ERR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({entry_err, exit_err})); // R4
   AST_HOLD_LOW: assert property (@(posedge clk) disable iff (!rst_n) (!cke_q && !cke) |=> (state_q == $past(state_q)) && !entry_err && !exit_err); // R5
   AST_EXIT_TO_ON: assert property (@(posedge clk) disable iff (!rst_n) (rise && state_q != PS_ON) |=> (state_q == PS_ON)); // R6
   AST_NO_REQ_IN_SREF: assert property (@(posedge clk) disable iff (!rst_n) (state_q == PS_SREF) |-> !ref_req); // R9

endmodule

// File: tb/lpm_ctrl_test.sv
module lpm_ctrl_test;

   localparam int ROW_W = 2;
   localparam int BANK_W = 2;
   localparam int REFI = 16;
   localparam int EXIT_CYC = 4;

   localparam logic [3:0] C_NOP  = 4'b0111;
   localparam logic [3:0] C_DESL = 4'b1111;
   localparam logic [3:0] C_REF  = 4'b0001;
   localparam logic [3:0] C_ACT  = 4'b0011;
   localparam logic [3:0] C_RD   = 4'b0101;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cke = 1'b1;
   logic cs_n, ras_n, cas_n, we_n;
   logic all_idle = 1'b1;
   logic [2:0] pasr_sel = 3'b000;
   logic [1:0] pwr_state;
   logic ref_req;
   logic [BANK_W+ROW_W-1:0] ref_addr;
   logic entry_err, exit_err, early_err, pulse_err;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   assign {cs_n, ras_n, cas_n, we_n} = cmd;
   logic [3:0] cmd = 4'b0111;

   lpm_ctrl #(
      .ROW_W(ROW_W), .BANK_W(BANK_W), .REFI(REFI), .EXIT_CYC(EXIT_CYC), .CKE_MIN(2), .ALLOW_ACT_PD(1'b0)
   ) uut (
      .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
      .all_idle(all_idle), .pasr_sel(pasr_sel), .pwr_state(pwr_state), .ref_req(ref_req),
      .ref_addr(ref_addr), .entry_err(entry_err), .exit_err(exit_err), .early_err(early_err),
      .pulse_err(pulse_err)
   );

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic drive(input logic c, input logic [3:0] k);
      cke = c;
      cmd = k;
      step();
   endtask

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: got %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      cke = 1'b1;
      cmd = C_NOP;
      all_idle = 1'b1;
      pasr_sel = 3'b000;
      step();
      step();
      rst_n = 1'b1;
   endtask

   task automatic t_reset();
      do_reset();
      chk("R1 state", pwr_state, 0);
      chk("R1 ref_req", ref_req, 0);
      chk("R1 ref_addr", ref_addr, 0);
      chk("R1 error flags", {entry_err, exit_err, early_err, pulse_err}, 0);
   endtask

   task automatic t_interval();
      int n = 0;
      int m = 0;
      while (!ref_req && n < 100) begin
         step();
         n++;
      end
      chk("R9 first request edge", n, REFI);
      step();
      chk("R9 request width", ref_req, 0);
      m = 1;
      while (!ref_req && m < 100) begin
         step();
         m++;
      end
      chk("R9 request period", m, REFI);
   endtask

   task automatic t_auto_ref();
      do_reset();
      for (int i = 0; i < 5; i++) drive(1'b1, C_REF);
      chk("R10 auto-refresh count", ref_addr, 5);
      all_idle = 1'b0;
      drive(1'b1, C_REF);
      drive(1'b1, C_REF);
      chk("R10 refresh with busy banks", ref_addr, 5);
      all_idle = 1'b1;
      drive(1'b1, C_NOP);
   endtask

   task automatic t_sref_quarter();
      int bad = 0;
      pasr_sel = 3'b010;
      drive(1'b0, C_REF);
      chk("R2 self-refresh entry", pwr_state, 3);
      cmd = C_ACT;
      for (int i = 1; i < 50; i++) begin
         cmd = (i % 2 == 0) ? C_REF : C_ACT;
         step();
         if (ref_req || entry_err || exit_err || early_err || pulse_err || pwr_state != 2'b11) bad++;
      end
      step();
      chk("R5 commands ignored in self-refresh", bad, 0);
      chk("R11 quarter array after 3 intervals", ref_addr, 2);
      for (int i = 0; i < 36; i++) step();
      chk("R11 quarter array wrap", ref_addr, 0);
      drive(1'b1, C_NOP);
      chk("R6 self-refresh exit", pwr_state, 0);
      chk("R6 clean exit flag", exit_err, 0);
      drive(1'b1, C_RD);
      chk("R7 column command in window", early_err, 0);
      drive(1'b1, C_NOP);
      drive(1'b1, C_NOP);
      drive(1'b1, C_ACT);
      chk("R7 activate on last window edge", early_err, 1);
      drive(1'b1, C_NOP);
      chk("R7 early flag width", early_err, 0);
      drive(1'b0, C_REF);
      drive(1'b0, C_NOP);
      drive(1'b1, C_NOP);
      for (int i = 0; i < EXIT_CYC; i++) drive(1'b1, C_NOP);
      drive(1'b1, C_ACT);
      chk("R7 activate after window", early_err, 0);
      drive(1'b1, C_NOP);
   endtask

   task automatic t_sref_half();
      do_reset();
      pasr_sel = 3'b001;
      drive(1'b0, C_REF);
      cmd = C_NOP;
      for (int i = 0; i < 117; i++) step();
      chk("R11 half array after 7 intervals", ref_addr, 7);
      for (int i = 0; i < 33; i++) step();
      chk("R11 half array wrap", ref_addr, 1);
      drive(1'b1, C_NOP);
      drive(1'b1, C_NOP);
   endtask

   task automatic t_power_down();
      logic [BANK_W+ROW_W-1:0] a0;
      a0 = ref_addr;
      drive(1'b0, C_NOP);
      chk("R3 power-down entry", pwr_state, 1);
      drive(1'b0, C_REF);
      drive(1'b0, C_REF);
      drive(1'b0, C_REF);
      chk("R5 mode held", pwr_state, 1);
      chk("R5 refresh ignored", ref_addr, a0);
      drive(1'b1, C_ACT);
      chk("R6 exit state", pwr_state, 0);
      chk("R6 exit with activate", exit_err, 1);
      drive(1'b1, C_NOP);
      chk("R6 exit flag width", exit_err, 0);
      drive(1'b0, C_DESL);
      chk("R3 entry on deselect", pwr_state, 1);
      drive(1'b0, C_NOP);
      drive(1'b1, C_DESL);
      chk("R6 exit on deselect", exit_err, 0);
      drive(1'b1, C_NOP);
   endtask

   task automatic t_illegal();
      all_idle = 1'b0;
      drive(1'b0, C_NOP);
      chk("R4 entry with busy banks flag", entry_err, 1);
      chk("R4 entry with busy banks state", pwr_state, 0);
      drive(1'b0, C_NOP);
      chk("R5 no repeat flag while low", entry_err, 0);
      drive(1'b1, C_NOP);
      drive(1'b1, C_NOP);
      drive(1'b0, C_REF);
      chk("R4 self-refresh with busy banks", entry_err, 1);
      drive(1'b0, C_NOP);
      drive(1'b1, C_NOP);
      drive(1'b1, C_NOP);
      all_idle = 1'b1;
      drive(1'b0, C_ACT);
      chk("R4 entry with activate flag", entry_err, 1);
      chk("R4 entry with activate state", pwr_state, 0);
      drive(1'b0, C_NOP);
      drive(1'b1, C_NOP);
      drive(1'b1, C_NOP);
   endtask

   task automatic t_pulse();
      drive(1'b0, C_NOP);
      drive(1'b1, C_NOP);
      chk("R8 one-edge low pulse", pulse_err, 1);
      chk("R6 state after short pulse", pwr_state, 0);
      drive(1'b1, C_NOP);
      drive(1'b1, C_NOP);
      drive(1'b0, C_NOP);
      drive(1'b0, C_NOP);
      drive(1'b1, C_NOP);
      chk("R8 two-edge low pulse", pulse_err, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog (all requirements): got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      @(negedge clk);
      t_reset();
      t_interval();
      t_auto_ref();
      t_sref_quarter();
      t_sref_half();
      t_power_down();
      t_illegal();
      t_pulse();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule